// File: doc/BRIEF.md
# Stacked DRAM Cache Tag Manager

This block is the cache-management logic placed between a plain host memory controller and a DRAM cache stack divided into 16 pseudo-channels. Pseudo-channel 15 holds only tags. The other 15 hold only line data. The host issues one request per cycle: an address, a command and write data. It never compares tags itself. From each request the manager derives a tag-channel access and a data-channel access, and it starts both in the same cycle. Two cycles later it returns a result code together with the line data.

The cache is direct mapped. Each tag entry stores a valid flag, a dirty flag and the upper address bits. Writes and fills are staged in a one-entry write buffer and committed to both channels one cycle later. A following request that reads the same set before the commit becomes visible in the arrays takes the staged or committing line instead. The tag and data arrays are behavioural and have a fixed read latency of one cycle.

Top module: `tdc_cache_mgr`

## Requirements
- R1: After reset, rsp_valid is low and every line is invalid, so the first read of any address reports code 11.
- R2: The request address is split into a set index (low SET_W bits) and a tag (the remaining upper bits). data_ch equals the set modulo 15, and data_row equals the set divided by 15.
- R3: In the cycle a request is presented, tag_launch and data_launch are both high. When no request is presented, both are low.
- R4: Each request gives exactly one response, with rsp_valid high in the cycle that starts two rising edges after the request was sampled. No response appears without a request.
- R5: rsp_result codes are 00 hit, 01 clean miss (valid line, other tag, not dirty), 10 dirty miss (valid line, other tag, dirty) and 11 invalid (valid flag clear). The code always describes the line as it stood before the request.
- R6: A read hit returns the stored line data on rsp_rdata. Any miss, write or fill returns zero.
- R7: A write hit replaces the line data and marks the line dirty.
- R8: A write that finds an invalid line or a clean miss installs the new tag, the new data and the dirty flag.
- R9: A write that finds a dirty miss changes nothing. The older dirty line stays readable.
- R10: A fill (req_cmd 2) installs the tag and data as a valid, clean line, whatever the line held before.
- R11: Reads (req_cmd 0) and the reserved command (req_cmd 3) never change a line.
- R12: A request that follows a write or fill to the same set, one or two cycles later, sees the updated line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present this cycle |
| req_cmd | input | 2 | 0 read, 1 write, 2 fill, 3 reserved (treated as read) |
| req_addr | input | ADDR_W | Line address, set in the low bits, tag above |
| req_wdata | input | DATA_W | Line data for write or fill |
| tag_launch | output | 1 | Tag-channel read started this cycle |
| data_launch | output | 1 | Data-channel read started this cycle |
| data_ch | output | 4 | Data pseudo-channel selected (0 to 14) |
| data_row | output | ROW_W | Row within the selected data channel |
| rsp_valid | output | 1 | Response present |
| rsp_result | output | 2 | Cache result code |
| rsp_rdata | output | DATA_W | Line data on a read hit, otherwise zero |

## Verification
The bench aims at back-to-back traffic to one set. A design without forwarding would answer these requests from stale array contents and report an invalid line where it should report a hit. It also checks that a write to a dirty-miss line has no effect, which a careless design would break by overwriting the older dirty owner. Fills on top of clean lines and write hits on filled lines check that the dirty flag moves correctly. A wrong flag would give the wrong miss code later. Sets 14, 15, 20 and 63 probe the channel and row split, where an off-by-one divisor would move lines onto the wrong channel.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
    localparam int NUM_PCH  = 16;
    localparam int DATA_PCH = NUM_PCH - 1;
    localparam int CH_W     = 4;

    typedef enum logic [1:0] {
        CMD_RD   = 2'd0,
        CMD_WR   = 2'd1,
        CMD_FILL = 2'd2,
        CMD_RSVD = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        RES_HIT   = 2'd0,
        RES_CLEAN = 2'd1,
        RES_DIRTY = 2'd2,
        RES_INVAL = 2'd3
    } res_e;
endpackage

// File: rtl/tdc_chan_map.sv
`timescale 1ns/1ps
module tdc_chan_map
    import tdc_pkg::*;
#(
    parameter int SET_W = 6,
    parameter int ROW_W = 3
) (
    input  logic [SET_W-1:0] set_i,
    output logic [CH_W-1:0]  ch_o,
    output logic [ROW_W-1:0] row_o
);
    always_comb begin
        ch_o  = CH_W'(32'(set_i) % DATA_PCH);
        row_o = ROW_W'(32'(set_i) / DATA_PCH);
    end
endmodule

// File: rtl/tdc_tag_chan.sv
`timescale 1ns/1ps
module tdc_tag_chan #(
    parameter int SET_W = 6,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [SET_W-1:0] rd_set,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_dirty,
    output logic             rd_fire,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag
);
    localparam int SETS = 1 << SET_W;

    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  drt_q;

    assign rd_fire = rd_en;

    always_ff @(posedge clk) begin
        if (wr_en) tag_mem[wr_set] <= wr_tag;
        if (rd_en) rd_tag <= tag_mem[rd_set];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q    <= '0;
            drt_q    <= '0;
            rd_valid <= 1'b0;
            rd_dirty <= 1'b0;
        end else begin
            if (wr_en) begin
                vld_q[wr_set] <= 1'b1;
                drt_q[wr_set] <= wr_dirty;
            end
            if (rd_en) begin
                rd_valid <= vld_q[rd_set];
                rd_dirty <= drt_q[rd_set];
            end
        end
    end
endmodule

// File: rtl/tdc_data_chan.sv
`timescale 1ns/1ps
module tdc_data_chan
    import tdc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ROWS   = 5,
    parameter int ROW_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [CH_W-1:0]   rd_ch,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_fire,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] ch_rd [DATA_PCH];
    logic [CH_W-1:0]   sel_q;

    assign rd_fire = rd_en;

    for (genvar g = 0; g < DATA_PCH; g++) begin : g_pch
        logic [DATA_W-1:0] mem [ROWS];
        always_ff @(posedge clk) begin
            if (wr_en && wr_ch == CH_W'(g)) mem[wr_row] <= wr_data;
            if (rd_en && rd_ch == CH_W'(g)) ch_rd[g] <= mem[rd_row];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= '0;
        else if (rd_en) sel_q <= rd_ch;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < DATA_PCH; k++)
            if (sel_q == CH_W'(k)) rd_data = ch_rd[k];
    end

    AST_RD_CH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (32'(rd_ch) < DATA_PCH)) else $error("data channel out of range"); // R2
endmodule

// File: rtl/tdc_cache_mgr.sv
`timescale 1ns/1ps
module tdc_cache_mgr
    import tdc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int SET_W  = 6,
    parameter int DATA_W = 32,
    localparam int TAG_W = ADDR_W - SET_W,
    localparam int SETS  = 1 << SET_W,
    localparam int ROWS  = (SETS + DATA_PCH - 1) / DATA_PCH,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              tag_launch,
    output logic              data_launch,
    output logic [3:0]        data_ch,
    output logic [ROW_W-1:0]  data_row,
    output logic              rsp_valid,
    output logic [1:0]        rsp_result,
    output logic [DATA_W-1:0] rsp_rdata
);
    typedef struct packed {
        logic              v;
        logic [SET_W-1:0]  set;
        logic [TAG_W-1:0]  tag;
        logic              dirty;
        logic [DATA_W-1:0] data;
    } line_t;

    typedef struct packed {
        logic              s1_v;
        logic [1:0]        s1_cmd;
        logic [SET_W-1:0]  s1_set;
        logic [TAG_W-1:0]  s1_tag;
        logic [DATA_W-1:0] s1_wdata;
        line_t             wb;
        line_t             cm;
        logic              rsp_v;
        logic [1:0]        rsp_res;
        logic [DATA_W-1:0] rsp_data;
    } st_t;

    st_t st_d, st_q;

    logic [SET_W-1:0]  req_set;
    logic [TAG_W-1:0]  req_tag;
    logic [CH_W-1:0]   wb_ch;
    logic [ROW_W-1:0]  wb_row;
    logic              t_valid, t_dirty;
    logic [TAG_W-1:0]  t_tag;
    logic [DATA_W-1:0] d_data;

    assign req_set = req_addr[SET_W-1:0];
    assign req_tag = req_addr[ADDR_W-1:SET_W];

    tdc_chan_map #(.SET_W(SET_W), .ROW_W(ROW_W)) u_req_map (
        .set_i(req_set), .ch_o(data_ch), .row_o(data_row)
    );

    tdc_chan_map #(.SET_W(SET_W), .ROW_W(ROW_W)) u_wb_map (
        .set_i(st_q.wb.set), .ch_o(wb_ch), .row_o(wb_row)
    );

    tdc_tag_chan #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tag (
        .clk(clk), .rst_n(rst_n),
        .rd_en(req_valid), .rd_set(req_set),
        .wr_en(st_q.wb.v), .wr_set(st_q.wb.set), .wr_tag(st_q.wb.tag),
        .wr_dirty(st_q.wb.dirty),
        .rd_fire(tag_launch), .rd_valid(t_valid), .rd_dirty(t_dirty), .rd_tag(t_tag)
    );

    tdc_data_chan #(.DATA_W(DATA_W), .ROWS(ROWS), .ROW_W(ROW_W)) u_data (
        .clk(clk), .rst_n(rst_n),
        .rd_en(req_valid), .rd_ch(data_ch), .rd_row(data_row),
        .wr_en(st_q.wb.v), .wr_ch(wb_ch), .wr_row(wb_row), .wr_data(st_q.wb.data),
        .rd_fire(data_launch), .rd_data(d_data)
    );

    always_comb begin
        logic              e_v, e_dirty, hit;
        logic [TAG_W-1:0]  e_tag;
        logic [DATA_W-1:0] e_data;
        logic [1:0]        res;

        st_d = st_q;

        // line state as seen by the request now in the compare stage
        e_v = t_valid; e_dirty = t_dirty; e_tag = t_tag; e_data = d_data;
        if (st_q.cm.v && st_q.cm.set == st_q.s1_set) begin
            e_v = 1'b1; e_dirty = st_q.cm.dirty; e_tag = st_q.cm.tag; e_data = st_q.cm.data;
        end
        if (st_q.wb.v && st_q.wb.set == st_q.s1_set) begin
            e_v = 1'b1; e_dirty = st_q.wb.dirty; e_tag = st_q.wb.tag; e_data = st_q.wb.data;
        end

        hit = e_v && (e_tag == st_q.s1_tag);
        if (!e_v)         res = RES_INVAL;
        else if (hit)     res = RES_HIT;
        else if (e_dirty) res = RES_DIRTY;
        else              res = RES_CLEAN;

        st_d.cm       = st_q.wb;
        st_d.wb       = '0;
        st_d.rsp_v    = st_q.s1_v;
        st_d.rsp_res  = st_q.s1_v ? res : 2'd0;
        st_d.rsp_data = '0;

        if (st_q.s1_v) begin
            case (cmd_e'(st_q.s1_cmd))
                CMD_WR: begin
                    if (res != RES_DIRTY)
                        st_d.wb = '{v: 1'b1, set: st_q.s1_set, tag: st_q.s1_tag,
                                    dirty: 1'b1, data: st_q.s1_wdata};
                end
                CMD_FILL: begin
                    st_d.wb = '{v: 1'b1, set: st_q.s1_set, tag: st_q.s1_tag,
                                dirty: 1'b0, data: st_q.s1_wdata};
                end
                default: begin
                    if (hit) st_d.rsp_data = e_data;
                end
            endcase
        end

        st_d.s1_v     = req_valid;
        st_d.s1_cmd   = req_cmd;
        st_d.s1_set   = req_set;
        st_d.s1_tag   = req_tag;
        st_d.s1_wdata = req_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid  = st_q.rsp_v;
    assign rsp_result = st_q.rsp_res;
    assign rsp_rdata  = st_q.rsp_data;

    AST_LAUNCH_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        tag_launch == data_launch) else $error("tag and data launch split"); // R3
    AST_RSP_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ##1 rsp_valid) else $error("missing response"); // R4
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ##1 !rsp_valid) else $error("response without request"); // R4
    AST_MISS_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_result != 2'd0) |-> rsp_rdata == '0) else $error("miss data leaked"); // R6
endmodule

// File: tb/tb_tdc_cache_mgr.sv
`timescale 1ns/1ps
module tb_tdc_cache_mgr;
    localparam int ADDR_W = 10;
    localparam int SET_W  = 6;
    localparam int DATA_W = 32;
    localparam int ROW_W  = 3;

    typedef struct packed {
        logic [1:0]  cmd;
        logic [3:0]  tag;
        logic [5:0]  set;
        logic [31:0] wdata;
        logic [1:0]  res;
        logic [31:0] rdata;
    } vec_t;

    localparam int NV = 20;
    // cmd: 0 rd, 1 wr, 2 fill; res: 0 hit, 1 clean, 2 dirty, 3 invalid
    localparam vec_t VEC [NV] = '{
        '{2'd0, 4'd1, 6'd5,  32'h0,      2'd3, 32'h0},      // R1 R5
        '{2'd1, 4'd1, 6'd5,  32'h0000A1A1, 2'd3, 32'h0},    // R8
        '{2'd0, 4'd1, 6'd5,  32'h0,      2'd0, 32'h0000A1A1}, // R12 R6
        '{2'd0, 4'd2, 6'd5,  32'h0,      2'd2, 32'h0},      // R12 R5
        '{2'd1, 4'd2, 6'd5,  32'h0000B2B2, 2'd2, 32'h0},    // R9
        '{2'd0, 4'd1, 6'd5,  32'h0,      2'd0, 32'h0000A1A1}, // R9
        '{2'd2, 4'd4, 6'd9,  32'h0000F4F4, 2'd3, 32'h0},    // R10
        '{2'd0, 4'd4, 6'd9,  32'h0,      2'd0, 32'h0000F4F4}, // R10
        '{2'd0, 4'd6, 6'd9,  32'h0,      2'd1, 32'h0},      // R5 R10
        '{2'd1, 4'd6, 6'd9,  32'h00006666, 2'd1, 32'h0},    // R8
        '{2'd0, 4'd4, 6'd9,  32'h0,      2'd2, 32'h0},      // R8
        '{2'd0, 4'd6, 6'd9,  32'h0,      2'd0, 32'h00006666}, // R8
        '{2'd2, 4'd7, 6'd20, 32'h00007777, 2'd3, 32'h0},    // R10
        '{2'd1, 4'd7, 6'd20, 32'h0000C0DE, 2'd0, 32'h0},    // R7
        '{2'd0, 4'd0, 6'd20, 32'h0,      2'd2, 32'h0},      // R7
        '{2'd0, 4'd7, 6'd20, 32'h0,      2'd0, 32'h0000C0DE}, // R7
        '{2'd0, 4'd1, 6'd63, 32'h0,      2'd3, 32'h0},      // R5
        '{2'd2, 4'd2, 6'd63, 32'h00002222, 2'd3, 32'h0},    // R10
        '{2'd2, 4'd3, 6'd63, 32'h00003333, 2'd1, 32'h0},    // R10
        '{2'd0, 4'd3, 6'd63, 32'h0,      2'd0, 32'h00003333}  // R10
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_cmd = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              tag_launch, data_launch;
    logic [3:0]        data_ch;
    logic [ROW_W-1:0]  data_row;
    logic              rsp_valid;
    logic [1:0]        rsp_result;
    logic [DATA_W-1:0] rsp_rdata;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tdc_cache_mgr #(.ADDR_W(ADDR_W), .SET_W(SET_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .tag_launch(tag_launch),
        .data_launch(data_launch), .data_ch(data_ch), .data_row(data_row),
        .rsp_valid(rsp_valid), .rsp_result(rsp_result), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] cmd, input logic [3:0] tag, input logic [5:0] set,
                         input logic [31:0] wd);
        req_valid = 1'b1; req_cmd = cmd; req_addr = {tag, set}; req_wdata = wd;
    endtask

    task automatic check_map(input logic [5:0] set);
        #1;
        chk(tag_launch && data_launch, "R3 launch", {30'd0, tag_launch, data_launch}, 32'd3);
        chk(data_ch == 4'(set % 15), "R2 channel", 32'(data_ch), 32'(set % 15));
        chk(data_row == 3'(set / 15), "R2 row", 32'(data_row), 32'(set / 15));
    endtask

    task automatic check_rsp(input string tagname, input logic [1:0] res, input logic [31:0] rd);
        chk(rsp_valid == 1'b1, {tagname, " R4 valid"}, 32'(rsp_valid), 32'd1);
        chk(rsp_result == res, {tagname, " R5 result"}, 32'(rsp_result), 32'(res));
        chk(rsp_rdata == rd, {tagname, " R6 data"}, rsp_rdata, rd);
    endtask

    task automatic single(input logic [1:0] cmd, input logic [3:0] tag, input logic [5:0] set,
                          input logic [31:0] wd, input logic [1:0] res, input logic [31:0] rd,
                          input string tagname);
        drive(cmd, tag, set, wd);
        check_map(set);
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(posedge clk); #1;
        check_rsp(tagname, res, rd);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk(!tag_launch && !data_launch, "R3 idle launch", {30'd0, tag_launch, data_launch}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // back-to-back table walk: response for vector i-1 after edge i
        for (int i = 0; i <= NV; i++) begin
            if (i < NV) begin
                drive(VEC[i].cmd, VEC[i].tag, VEC[i].set, VEC[i].wdata);
                check_map(VEC[i].set);
            end else begin
                req_valid = 1'b0;
                #1;
            end
            @(posedge clk); #1;
            if (i >= 1) check_rsp($sformatf("vec%0d", i - 1), VEC[i-1].res, VEC[i-1].rdata);
        end

        // R4: idle gives no response
        repeat (3) begin
            @(posedge clk); #1;
            chk(rsp_valid == 1'b0, "R4 idle no rsp", 32'(rsp_valid), 32'd0);
        end

        // R11 / R9: lines read from the arrays after everything committed
        single(2'd0, 4'd1, 6'd5,  32'h0, 2'd0, 32'h0000A1A1, "R11 R9 s5");
        single(2'd0, 4'd6, 6'd9,  32'h0, 2'd0, 32'h00006666, "R11 s9");
        single(2'd3, 4'd5, 6'd63, 32'h0, 2'd1, 32'h0,        "R11 rsvd");
        single(2'd0, 4'd3, 6'd63, 32'h0, 2'd0, 32'h00003333, "R11 after rsvd");
        single(2'd0, 4'd0, 6'd14, 32'h0, 2'd3, 32'h0,        "R2 s14");
        single(2'd0, 4'd0, 6'd15, 32'h0, 2'd3, 32'h0,        "R2 s15");

        // R1: reset clears every line
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        single(2'd0, 4'd1, 6'd5, 32'h0, 2'd3, 32'h0, "R1 after reset");

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule